// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block turns a single request from a processor core into one bus cycle on a bus whose low address byte and data byte share the same lines. The core supplies a cycle kind (opcode fetch, memory read, memory write or halt), a 16-bit address and, for a write, a data byte. The sequencer puts the upper address byte on dedicated lines. It sends the low address byte on the shared lines with an address latch strobe, so that an external latch can demultiplex it. It then uses those same lines for data, and frames the transfer with active-low read or write strobes.

Every non-halt cycle takes exactly three clocks: T1 carries the address, and T2 and T3 carry the data. A two-bit status code goes out with the cycle, so peripherals can tell the cycle kind from T1 onward. The outputs that can float are given as value/enable pairs. This lets the chip-level pad ring build the tri-state drivers. They release during a hold (bus handed to another master) and while the sequencer is halted. The core sees a busy flag, a one-clock done pulse and, after a read or fetch, the captured byte.

Top module: `muxbus_seq`

## Requirements
- R1: A request is accepted only on a clock edge where `busy` is low and `req_valid` is high. `busy` is high during T1, T2 and T3 and while `hold` is high. A request presented while busy has no effect on the cycle in progress and does not start a later cycle.
- R2: In T1, `ale` is 1, `ctl_oe` and `ad_oe` are 1, `ad_o` carries address bits [7:0], `addr_hi` carries address bits [15:8], and both `rd_n` and `wr_n` are 1.
- R3: The status code `status` equals the kind code during T1, T2 and T3. Kind codes are 2'b11 opcode fetch, 2'b10 memory read, 2'b01 memory write and 2'b00 halt. `status` is 2'b00 when no cycle runs.
- R4: In T2 and T3 of a read or fetch, `rd_n` is 0, `wr_n` is 1 and `ad_oe` is 0. The byte on `ad_i` at the clock edge that ends T3 appears on `rdata` in the next clock.
- R5: In T2 and T3 of a write, `wr_n` is 0, `rd_n` is 1, `ad_oe` is 1 and `ad_o` carries the write byte. `wr_n` returns to 1 when T3 ends.
- R6: A non-halt cycle lasts exactly three clocks after the accepting edge. `done` is high for exactly the one clock that follows T3, and `busy` is low in that clock.
- R7: An accepted halt request starts no T-states. From the next clock, `ctl_oe` and `ad_oe` are 0, `status` is 2'b00 and `done` pulses once. The block stays floated until a new request is accepted.
- R8: `hold` sampled high at an edge while no cycle is running makes `ctl_oe` and `ad_oe` 0 from the next clock. A cycle already started runs to completion first. Releasing `hold` makes `ctl_oe` 1 again after one edge.
- R9: `ale` is high for exactly one clock per non-halt cycle and never while `rd_n` or `wr_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core presents a request |
| req_kind | input | 2 | Cycle kind code (see R3) |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write byte |
| hold | input | 1 | Another master asks for the bus |
| busy | output | 1 | Request would not be accepted now |
| done | output | 1 | One-clock pulse at cycle end |
| rdata | output | 8 | Byte captured by the last read or fetch |
| addr_hi | output | 8 | Upper address lines (value) |
| ad_o | output | 8 | Shared address/data lines (driven value) |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_i | input | 8 | Shared lines as seen from the bus |
| ale | output | 1 | Address latch strobe |
| status | output | 2 | Cycle status code |
| rd_n | output | 1 | Active-low read strobe (value) |
| wr_n | output | 1 | Active-low write strobe (value) |
| ctl_oe | output | 1 | Drive enable for addr_hi, rd_n and wr_n |

## Verification
The bench runs random cycles back to back and models a memory that drives the shared lines only while the read strobe is low. This exposes a sequencer that samples read data one clock early or late, or that keeps driving the shared lines into T2 of a read and fights the memory. Directed cases present requests while busy, which catches a design that queues them or corrupts the running cycle. They raise hold in the middle of a cycle, which catches one that aborts instead of finishing. They issue a halt followed by a fresh request, which catches one that never floats, or never leaves the floated state.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
   typedef enum logic [1:0] {
      K_HALT  = 2'b00,
      K_WRITE = 2'b01,
      K_READ  = 2'b10,
      K_FETCH = 2'b11
   } kind_e;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_T1   = 3'd1,
      PH_T2   = 3'd2,
      PH_T3   = 3'd3,
      PH_HALT = 3'd4
   } phase_e;

   function automatic logic is_rd(input kind_e k);
      return (k == K_READ) || (k == K_FETCH);
   endfunction
endpackage

// File: rtl/muxbus_phase.sv
module muxbus_phase
   import muxbus_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   req_valid,
   input  kind_e  req_kind,
   input  logic   hold,
   output phase_e phase_q,
   output phase_e phase_d,
   output kind_e  kind_q,
   output logic   accept,
   output logic   busy,
   output logic   done
);
   logic rest;
   logic done_d;

   assign rest   = (phase_q == PH_IDLE) || (phase_q == PH_HALT);
   assign busy   = !rest || hold;
   assign accept = rest && req_valid && !hold;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_T1:   phase_d = PH_T2;
         PH_T2:   phase_d = PH_T3;
         PH_T3:   phase_d = PH_IDLE;
         default: if (accept) phase_d = (req_kind == K_HALT) ? PH_HALT : PH_T1;
      endcase
   end

   assign done_d = (phase_q == PH_T3) || (accept && req_kind == K_HALT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         kind_q  <= K_HALT;
         done    <= 1'b0;
      end else begin
         phase_q <= phase_d;
         done    <= done_d;
         if (accept) kind_q <= req_kind;
      end
   end
endmodule

// File: rtl/muxbus_pins.sv
module muxbus_pins
   import muxbus_pkg::*;
#(
   parameter int HI_W = 8,
   parameter int LO_W = 8,
   localparam int ADDR_W = HI_W + LO_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  phase_e            phase_d,
   input  logic              accept,
   input  logic              hold,
   input  kind_e             req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LO_W-1:0]   req_wdata,
   output logic [HI_W-1:0]   addr_hi,
   output logic [LO_W-1:0]   ad_o,
   output logic              ad_oe,
   output logic              ale,
   output logic [1:0]        status,
   output logic              rd_n,
   output logic              wr_n,
   output logic              ctl_oe
);
   kind_e             kind_h, kind_c;
   logic [ADDR_W-1:0] addr_h, addr_c;
   logic [LO_W-1:0]   wd_h, wd_c;

   logic [HI_W-1:0] hi_n;
   logic [LO_W-1:0] ad_n;
   logic            ad_oe_n, ale_n, rd_n_n, wr_n_n, ctl_oe_n;
   logic [1:0]      st_n;

   assign kind_c = accept ? req_kind  : kind_h;
   assign addr_c = accept ? req_addr  : addr_h;
   assign wd_c   = accept ? req_wdata : wd_h;

   always_comb begin
      hi_n     = addr_c[ADDR_W-1:LO_W];
      ad_n     = addr_c[LO_W-1:0];
      ad_oe_n  = 1'b0;
      ale_n    = 1'b0;
      rd_n_n   = 1'b1;
      wr_n_n   = 1'b1;
      st_n     = 2'b00;
      ctl_oe_n = !hold;
      unique case (phase_d)
         PH_T1: begin
            ale_n    = 1'b1;
            ad_oe_n  = 1'b1;
            st_n     = kind_c;
            ctl_oe_n = 1'b1;
         end
         PH_T2, PH_T3: begin
            st_n     = kind_c;
            ctl_oe_n = 1'b1;
            rd_n_n   = !is_rd(kind_c);
            wr_n_n   = (kind_c != K_WRITE);
            ad_oe_n  = (kind_c == K_WRITE);
            ad_n     = wd_c;
         end
         PH_HALT: ctl_oe_n = 1'b0;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_h  <= K_HALT;
         addr_h  <= '0;
         wd_h    <= '0;
         addr_hi <= '0;
         ad_o    <= '0;
         ad_oe   <= 1'b0;
         ale     <= 1'b0;
         status  <= 2'b00;
         rd_n    <= 1'b1;
         wr_n    <= 1'b1;
         ctl_oe  <= 1'b1;
      end else begin
         kind_h  <= kind_c;
         addr_h  <= addr_c;
         wd_h    <= wd_c;
         addr_hi <= hi_n;
         ad_o    <= ad_n;
         ad_oe   <= ad_oe_n;
         ale     <= ale_n;
         status  <= st_n;
         rd_n    <= rd_n_n;
         wr_n    <= wr_n_n;
         ctl_oe  <= ctl_oe_n;
      end
   end
endmodule

// File: rtl/muxbus_rdcap.sv
module muxbus_rdcap
   import muxbus_pkg::*;
#(
   parameter int  DATA_W     = 8,
   parameter bit  KEEP_RDATA = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  phase_e            phase_q,
   input  kind_e             kind_q,
   input  logic [DATA_W-1:0] ad_i,
   output logic [DATA_W-1:0] rdata
);
   logic grab;
   assign grab = (phase_q == PH_T3) && is_rd(kind_q);

   generate
      if (KEEP_RDATA) begin : g_keep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    rdata <= '0;
            else if (grab) rdata <= ad_i;
         end
      end else begin : g_pulse
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= grab ? ad_i : '0;
         end
      end
   endgenerate
endmodule

// File: rtl/muxbus_seq.sv
module muxbus_seq
   import muxbus_pkg::*;
#(
   parameter int HI_W       = 8,
   parameter int LO_W       = 8,
   parameter int DATA_W     = 8,
   parameter bit KEEP_RDATA = 1'b1,
   localparam int ADDR_W = HI_W + LO_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              hold,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic [HI_W-1:0]   addr_hi,
   output logic [LO_W-1:0]   ad_o,
   output logic              ad_oe,
   input  logic [LO_W-1:0]   ad_i,
   output logic              ale,
   output logic [1:0]        status,
   output logic              rd_n,
   output logic              wr_n,
   output logic              ctl_oe
);
   generate
      if (DATA_W != LO_W) begin : g_bad_width
         $error("muxbus_seq: DATA_W must equal LO_W, the shared lines carry both");
      end
      if (HI_W < 1 || LO_W < 1) begin : g_bad_addr
         $error("muxbus_seq: address halves must be at least one bit");
      end
   endgenerate

   phase_e phase_q, phase_d;
   kind_e  kind_q;
   logic   accept;

   muxbus_phase u_phase (
      .clk, .rst_n, .req_valid,
      .req_kind (kind_e'(req_kind)),
      .hold, .phase_q, .phase_d, .kind_q, .accept, .busy, .done
   );

   muxbus_pins #(.HI_W(HI_W), .LO_W(LO_W)) u_pins (
      .clk, .rst_n, .phase_d, .accept, .hold,
      .req_kind (kind_e'(req_kind)),
      .req_addr,
      .req_wdata,
      .addr_hi, .ad_o, .ad_oe, .ale, .status, .rd_n, .wr_n, .ctl_oe
   );

   muxbus_rdcap #(.DATA_W(DATA_W), .KEEP_RDATA(KEEP_RDATA)) u_rdcap (
      .clk, .rst_n, .phase_q, .kind_q, .ad_i, .rdata
   );
endmodule

// File: rtl/muxbus_seq_chk.sv
module muxbus_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       done,
   input logic       ad_oe,
   input logic       ale,
   input logic       rd_n,
   input logic       wr_n,
   input logic       ctl_oe,
   input logic [1:0] status
);
   AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n) ale |-> (rd_n && wr_n)); // R9
   AST_ALE_ONE_CLK:   assert property (@(posedge clk) disable iff (!rst_n) ale |=> !ale); // R9
   AST_ALE_ADDR_OUT:  assert property (@(posedge clk) disable iff (!rst_n) ale |-> (ad_oe && ctl_oe && busy)); // R2
   AST_RD_RELEASES:   assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !ad_oe); // R4
   AST_ONE_STROBE:    assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n)); // R4
   AST_WR_DRIVES:     assert property (@(posedge clk) disable iff (!rst_n) !wr_n |-> (ad_oe && status == 2'b01)); // R5
   AST_DONE_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
   AST_FLOAT_BOTH:    assert property (@(posedge clk) disable iff (!rst_n) !ctl_oe |-> !ad_oe); // R7
endmodule

bind muxbus_seq muxbus_seq_chk u_chk (
   .clk, .rst_n, .busy, .done, .ad_oe, .ale, .rd_n, .wr_n, .ctl_oe, .status
);

// File: tb/sim_muxbus_seq.sv
module sim_muxbus_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_kind = 2'b00;
   logic [15:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic       hold = 1'b0;
   logic       busy, done, ad_oe, ale, rd_n, wr_n, ctl_oe;
   logic [7:0] rdata, addr_hi, ad_o, ad_i;
   logic [1:0] status;
   logic [15:0] lat_addr = '0;

   int tests = 0;
   int fails = 0;

   always #2 clk = ~clk;

   muxbus_seq u0 (
      .clk, .rst_n, .req_valid, .req_kind, .req_addr, .req_wdata, .hold,
      .busy, .done, .rdata, .addr_hi, .ad_o, .ad_oe, .ad_i, .ale, .status,
      .rd_n, .wr_n, .ctl_oe
   );

   function automatic logic [7:0] mem_val(input logic [15:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
   endfunction

   assign ad_i = !rd_n ? mem_val(lat_addr) : 8'h00;

   always @(negedge clk) if (ale) lat_addr <= {addr_hi, ad_o};

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one full non-halt cycle, optionally offering a stray request while busy
   task automatic run_cycle(input logic [1:0] k, input logic [15:0] a,
                            input logic [7:0] d, input logic stray);
      logic rdk;
      rdk = (k == 2'b10) || (k == 2'b11);
      @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = d;
      @(negedge clk);                       // T1
      req_valid = stray; req_kind = 2'b01; req_addr = ~a; req_wdata = ~d;
      chk(ale == 1'b1, "R2 ale in T1", ale, 1);
      chk(ad_oe && ctl_oe && ad_o == a[7:0] && addr_hi == a[15:8], "R2 address out", {addr_hi, ad_o}, a);
      chk(rd_n && wr_n, "R2 strobes idle in T1", {rd_n, wr_n}, 3);
      chk(status == k, "R3 status T1", status, k);
      chk(busy == 1'b1, "R1 busy T1", busy, 1);
      for (int t = 2; t <= 3; t++) begin
         @(negedge clk);                    // T2, T3
         chk(ale == 1'b0, "R9 ale low after T1", ale, 0);
         chk(status == k, "R3 status T2/T3", status, k);
         if (rdk) begin
            chk(!rd_n && wr_n && !ad_oe, "R4 read strobe and release", {rd_n, wr_n, ad_oe}, 3'b010);
         end else begin
            chk(!wr_n && rd_n && ad_oe && ad_o == d, "R5 write strobe and data", {wr_n, rd_n, ad_o}, {2'b01, d});
         end
         chk(addr_hi == a[15:8], "R2 upper address held", addr_hi, a[15:8]);
         chk(done == 1'b0, "R6 no early done", done, 0);
      end
      @(negedge clk);                       // after T3
      req_valid = 1'b0;
      chk(done == 1'b1 && busy == (hold ? 1'b1 : 1'b0), "R6 done after T3", {done, busy}, {1'b1, hold});
      chk(rd_n && wr_n && !ad_oe, "R5 strobes return high", {rd_n, wr_n, ad_oe}, 3'b110);
      if (rdk) chk(rdata == mem_val(a), "R4 read data", rdata, mem_val(a));
      if (stray) begin
         @(negedge clk);
         chk(ale == 1'b0 && done == 1'b0, "R1 stray request ignored", {ale, done}, 0);
      end
   endtask

   initial begin
      #(4 * 200000);
      chk(1'b0, "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk(!busy && !done && !ale && rd_n && wr_n && !ad_oe && ctl_oe && status == 2'b00,
          "R1 reset state", {busy, done, ale, rd_n, wr_n, ad_oe, ctl_oe}, 7'b0001101);
      rst_n = 1'b1;
      @(negedge clk);

      // directed corners
      run_cycle(2'b11, 16'h0000, 8'h00, 1'b0);
      run_cycle(2'b01, 16'hFFFF, 8'hFF, 1'b0);
      run_cycle(2'b10, 16'h12AB, 8'h00, 1'b1);
      run_cycle(2'b01, 16'h8001, 8'h5C, 1'b1);

      // halt then leave it
      @(negedge clk);
      req_valid = 1'b1; req_kind = 2'b00; req_addr = 16'h4321;
      @(negedge clk);
      req_valid = 1'b0;
      chk(!ctl_oe && !ad_oe && status == 2'b00 && done && !busy && !ale, "R7 halt floats",
          {ctl_oe, ad_oe, status, done, busy}, 6'b000010);
      repeat (3) @(negedge clk);
      chk(!ctl_oe && !done, "R7 halt persists", {ctl_oe, done}, 0);
      run_cycle(2'b10, 16'h3C3C, 8'h00, 1'b0);
      chk(ctl_oe == 1'b1, "R7 halt left on request", ctl_oe, 1);

      // hold while idle
      hold = 1'b1;
      @(negedge clk);
      chk(!ctl_oe && !ad_oe && busy, "R8 hold floats", {ctl_oe, ad_oe, busy}, 3'b001);
      req_valid = 1'b1; req_kind = 2'b11; req_addr = 16'h7777;
      @(negedge clk);
      @(negedge clk);
      chk(!ale && !ctl_oe && rd_n, "R1 no accept under hold", {ale, ctl_oe, rd_n}, 3'b001);
      req_valid = 1'b0; hold = 1'b0;
      @(negedge clk);
      chk(ctl_oe && !busy, "R8 hold released", {ctl_oe, busy}, 2'b10);

      // hold raised mid-cycle: cycle completes, then floats
      fork
         run_cycle(2'b01, 16'h5A5A, 8'h3E, 1'b0);
         begin repeat (3) @(negedge clk); hold = 1'b1; end
      join
      @(negedge clk);
      chk(!ctl_oe && !ad_oe, "R8 float after finishing cycle", {ctl_oe, ad_oe}, 0);
      hold = 1'b0;
      @(negedge clk);

      // random mix
      for (int i = 0; i < 60; i++) begin
         logic [1:0] k;
         k = 2'($urandom_range(1, 3));
         run_cycle(k, 16'($urandom), 8'($urandom), 1'($urandom_range(0, 1)));
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule